// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block moves a processor core between its running state and four reduced-power states. The states are nap, doze, sleep and deep sleep. Each state sets its own clock-domain enables. Software asks for a low-power mode with a one-cycle strobe and a mode code. The controller then raises a quiesce request toward the system. It enters the chosen state only after the system acknowledges.

In nap, instruction fetch and the functional units stop. The time-base/decrementer and debug-port clocks keep running. A bus snoop request during nap moves the core into doze, where snooping is enabled, and the core falls back to nap once the snoop ends. Sleep also stops the time-base/decrementer and debug-port clocks and disables snooping. Only the PLL stays enabled in sleep. Deep sleep also drops the PLL enable.

A wake input returns the core to run from every low-power state. The exit from deep sleep first re-enables the PLL. It then waits for lock and counts a fixed settle period before the core clocks come back. A frequency-halving select follows software while the core runs and is frozen otherwise.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the outputs show run: every clock enable, snoop_en_o and pll_en_o are 1, qreq_o is 0 and half_freq_o is 0.
- R2: In run, mode_go_i=1 with mode_sel_i of 01 (nap), 10 (sleep) or 11 (deep sleep) raises qreq_o at the next clock edge. qreq_o stays high until qack_i is sampled high, and the selected state is entered at that same edge. mode_sel_i=00, and any mode_go_i outside run, leave the outputs unchanged.
- R3: Nap outputs: fetch and functional-unit enables 0, time-base and debug enables 1, snoop_en_o 0, pll_en_o 1, qreq_o 1.
- R4: In nap, snoop_req_i sampled high moves the block to doze at the next edge. Doze outputs are the nap outputs with snoop_en_o=1 and qreq_o=0. Doze holds while snoop_req_i is high and returns to nap at the first edge where it is low.
- R5: Sleep outputs: all four clock enables 0, snoop_en_o 0, pll_en_o 1, qreq_o 1. snoop_req_i has no effect in sleep.
- R6: Deep-sleep outputs equal the sleep outputs with pll_en_o=0. snoop_req_i has no effect in deep sleep.
- R7: wake_i sampled high in nap, doze, sleep or while waiting for the acknowledge returns to run at that edge. In nap, wake_i wins over snoop_req_i.
- R8: wake_i in deep sleep enters relock, where pll_en_o=1, all clock enables are 0 and qreq_o=1. After pll_lock_i is sampled high, SETTLE_CYC further edges with lock held pass before run. A loss of lock during the settle period restarts the wait for lock.
- R9: half_freq_o takes the value of dfs_i one edge after it is sampled in run. It holds its value in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_go_i | input | 1 | Low-power mode request strobe |
| mode_sel_i | input | 2 | Requested mode: 01 nap, 10 sleep, 11 deep sleep |
| qack_i | input | 1 | System quiesce acknowledge |
| snoop_req_i | input | 1 | Bus snoop pending |
| wake_i | input | 1 | Interrupt / wake event |
| pll_lock_i | input | 1 | PLL lock indication |
| dfs_i | input | 1 | Software frequency-halving request |
| qreq_o | output | 1 | Quiesce request to system |
| fetch_clk_en_o | output | 1 | Instruction fetch clock enable |
| tbdec_clk_en_o | output | 1 | Time-base/decrementer clock enable |
| jtag_clk_en_o | output | 1 | Debug port clock enable |
| fu_clk_en_o | output | 1 | Functional unit clock enable |
| snoop_en_o | output | 1 | Bus snoop logic enable |
| pll_en_o | output | 1 | PLL enable |
| half_freq_o | output | 1 | Core clock halving select |

## Verification
The bench holds the acknowledge low for several cycles. A design that entered the low-power state early, or dropped the request too soon, would show the wrong state there. It raises snoop during sleep and deep sleep, where a design that reacted would turn snoop_en_o on. It also raises snoop together with wake in nap, where a design with the wrong priority would land in doze.

On the deep-sleep exit, the bench counts the settle period exactly and drops lock partway through. An off-by-one counter would return to run one edge early or late. A counter that ignored lock loss would return to run with an unlocked PLL. The bench also changes the frequency select while the core is napping, where a design that did not freeze it would change half_freq_o.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_QUIESCE = 3'd1,
    ST_NAP     = 3'd2,
    ST_DOZE    = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_DSLEEP  = 3'd5,
    ST_RELOCK  = 3'd6,
    ST_SETTLE  = 3'd7
  } lpm_state_e;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_NAP   = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_DEEP  = 2'b11
  } lpm_mode_e;

  typedef struct packed {
    logic qreq;
    logic fetch;
    logic tbdec;
    logic jtag;
    logic fu;
    logic snoop;
    logic pll;
  } lpm_ctl_t;

endpackage

// File: rtl/lpm_settle.sv
module lpm_settle #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_en_i,
  output logic done_o
);
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (count_en_i) cnt_q <= (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    else                 cnt_q <= '0;
  end

  assign done_o = count_en_i && (cnt_q == LAST);

  // R8: counter restarts whenever settle is left
  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> (cnt_q == '0));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_go_i,
  input  logic [1:0] mode_sel_i,
  input  logic       qack_i,
  input  logic       snoop_req_i,
  input  logic       wake_i,
  input  logic       pll_lock_i,
  input  logic       settle_done_i,
  output lpm_state_e state_o
);
  lpm_state_e st_q, st_d;
  lpm_mode_e  tgt_q, tgt_d;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    unique case (st_q)
      ST_RUN: begin
        if (mode_go_i && (mode_sel_i != MODE_NONE)) begin
          st_d  = ST_QUIESCE;
          tgt_d = lpm_mode_e'(mode_sel_i);
        end
      end
      ST_QUIESCE: begin
        if (wake_i) st_d = ST_RUN;
        else if (qack_i) begin
          unique case (tgt_q)
            MODE_NAP:   st_d = ST_NAP;
            MODE_SLEEP: st_d = ST_SLEEP;
            MODE_DEEP:  st_d = ST_DSLEEP;
            default:    st_d = ST_RUN;
          endcase
        end
      end
      ST_NAP: begin
        if (wake_i)           st_d = ST_RUN;
        else if (snoop_req_i) st_d = ST_DOZE;
      end
      ST_DOZE: begin
        if (wake_i)            st_d = ST_RUN;
        else if (!snoop_req_i) st_d = ST_NAP;
      end
      ST_SLEEP:  if (wake_i) st_d = ST_RUN;
      ST_DSLEEP: if (wake_i) st_d = ST_RELOCK;
      ST_RELOCK: if (pll_lock_i) st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!pll_lock_i)        st_d = ST_RELOCK;
        else if (settle_done_i) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      tgt_q <= MODE_NONE;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  assign state_o = st_q;

  p_hold_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUIESCE && !qack_i && !wake_i) |=> (st_q == ST_QUIESCE));
  p_nap_to_doze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NAP && snoop_req_i && !wake_i) |=> (st_q == ST_DOZE));
  p_sleep_deaf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && !wake_i) |=> (st_q == ST_SLEEP));
  p_deep_deaf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DSLEEP && !wake_i) |=> (st_q == ST_DSLEEP));
  p_wake_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q inside {ST_NAP, ST_DOZE, ST_SLEEP, ST_QUIESCE}) && wake_i) |=> (st_q == ST_RUN));
  p_deep_relock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DSLEEP && wake_i) |=> (st_q == ST_RELOCK));
  p_lock_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SETTLE && !pll_lock_i) |=> (st_q == ST_RELOCK));
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  output lpm_ctl_t   ctl_o
);
  // field order: qreq fetch tbdec jtag fu snoop pll
  always_comb begin
    unique case (state_i)
      ST_RUN:     ctl_o = 7'b0111111;
      ST_QUIESCE: ctl_o = 7'b1111111;
      ST_NAP:     ctl_o = 7'b1011001;
      ST_DOZE:    ctl_o = 7'b0011011;
      ST_SLEEP:   ctl_o = 7'b1000001;
      ST_DSLEEP:  ctl_o = 7'b1000000;
      ST_RELOCK,
      ST_SETTLE:  ctl_o = 7'b1000001;
      default:    ctl_o = 7'b0111111;
    endcase
  end
endmodule

// File: rtl/lpm_dfs.sv
module lpm_dfs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic dfs_i,
  output logic half_freq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    half_freq_o <= 1'b0;
    else if (run_i) half_freq_o <= dfs_i;
  end

  p_dfs_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(half_freq_o));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_go_i,
  input  logic [1:0] mode_sel_i,
  input  logic       qack_i,
  input  logic       snoop_req_i,
  input  logic       wake_i,
  input  logic       pll_lock_i,
  input  logic       dfs_i,
  output logic       qreq_o,
  output logic       fetch_clk_en_o,
  output logic       tbdec_clk_en_o,
  output logic       jtag_clk_en_o,
  output logic       fu_clk_en_o,
  output logic       snoop_en_o,
  output logic       pll_en_o,
  output logic       half_freq_o
);
  lpm_state_e state;
  lpm_ctl_t   ctl;
  logic       settle_done;

  lpm_seq u_seq (
    .clk_i, .rst_ni, .mode_go_i, .mode_sel_i, .qack_i, .snoop_req_i,
    .wake_i, .pll_lock_i,
    .settle_done_i(settle_done),
    .state_o      (state)
  );

  lpm_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni,
    .count_en_i(state == ST_SETTLE),
    .done_o    (settle_done)
  );

  lpm_gate_dec u_dec (.state_i(state), .ctl_o(ctl));

  lpm_dfs u_dfs (
    .clk_i, .rst_ni,
    .run_i      (state == ST_RUN),
    .dfs_i,
    .half_freq_o
  );

  assign qreq_o         = ctl.qreq;
  assign fetch_clk_en_o = ctl.fetch;
  assign tbdec_clk_en_o = ctl.tbdec;
  assign jtag_clk_en_o  = ctl.jtag;
  assign fu_clk_en_o    = ctl.fu;
  assign snoop_en_o     = ctl.snoop;
  assign pll_en_o       = ctl.pll;

  // R6: PLL stays on whenever any core clock runs
  p_pll_for_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_clk_en_o || fu_clk_en_o) |-> pll_en_o);
endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE = 8;

  // qreq fetch tbdec jtag fu snoop pll
  localparam logic [6:0] V_RUN = 7'b0111111;
  localparam logic [6:0] V_QS  = 7'b1111111;
  localparam logic [6:0] V_NAP = 7'b1011001;
  localparam logic [6:0] V_DOZ = 7'b0011011;
  localparam logic [6:0] V_SLP = 7'b1000001;
  localparam logic [6:0] V_DSL = 7'b1000000;
  localparam logic [6:0] V_RLK = 7'b1000001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_go = 0, qack = 0, snoop = 0, wake = 0, lock = 0, dfs = 0;
  logic [1:0] mode_sel = 2'b00;
  logic qreq, fetch_en, tb_en, jtag_en, fu_en, snp_en, pll_en, half;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni, .mode_go_i(mode_go), .mode_sel_i(mode_sel),
    .qack_i(qack), .snoop_req_i(snoop), .wake_i(wake), .pll_lock_i(lock),
    .dfs_i(dfs), .qreq_o(qreq), .fetch_clk_en_o(fetch_en),
    .tbdec_clk_en_o(tb_en), .jtag_clk_en_o(jtag_en), .fu_clk_en_o(fu_en),
    .snoop_en_o(snp_en), .pll_en_o(pll_en), .half_freq_o(half)
  );

  function automatic logic [7:0] obs();
    return {qreq, fetch_en, tb_en, jtag_en, fu_en, snp_en, pll_en, half};
  endfunction

  task automatic cmp(input logic [7:0] exp, input string tag);
    n_chk++;
    if (obs() !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  // monitor: pops expected outputs after each edge
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) cmp(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic step(input logic go, input logic [1:0] sel, input logic ack,
                      input logic snp, input logic wk, input logic lk, input logic df,
                      input logic [6:0] ev, input logic eh, input string tag);
    @(negedge clk);
    mode_go = go; mode_sel = sel; qack = ack; snoop = snp; wake = wk; lock = lk; dfs = df;
    @(posedge clk);
    #1;
    exp_q.push_back({ev, eh});
    tag_q.push_back(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1ns);
    cmp({V_RUN, 1'b0}, "R1 reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0, 2'b00, 0, 0, 0, 0, 0, V_RUN, 0, "R1 idle run");
    step(0, 2'b00, 0, 0, 0, 0, 1, V_RUN, 1, "R9 dfs in run");
    step(1, 2'b00, 0, 0, 0, 0, 1, V_RUN, 1, "R2 sel 00 ignored");
    step(1, 2'b01, 0, 0, 0, 0, 1, V_QS,  1, "R2 nap request");
    step(0, 2'b00, 0, 0, 0, 0, 1, V_QS,  1, "R2 wait ack 1");
    step(1, 2'b10, 0, 0, 0, 0, 1, V_QS,  1, "R2 wait ack 2");
    step(0, 2'b00, 1, 0, 0, 0, 0, V_NAP, 1, "R3 nap entered");
    step(0, 2'b00, 0, 0, 0, 0, 0, V_NAP, 1, "R9 frozen in nap");
    step(0, 2'b00, 0, 1, 0, 0, 0, V_DOZ, 1, "R4 snoop to doze");
    step(0, 2'b00, 0, 1, 0, 0, 0, V_DOZ, 1, "R4 doze held");
    step(0, 2'b00, 0, 0, 0, 0, 0, V_NAP, 1, "R4 back to nap");
    step(1, 2'b10, 0, 0, 0, 0, 0, V_NAP, 1, "R2 go outside run ignored");
    step(0, 2'b00, 0, 1, 1, 0, 0, V_RUN, 1, "R7 wake beats snoop");
    step(0, 2'b00, 0, 0, 0, 0, 1, V_RUN, 1, "R9 run resumes");
    step(1, 2'b10, 0, 0, 0, 0, 1, V_QS,  1, "R2 sleep request");
    step(0, 2'b00, 1, 0, 0, 0, 1, V_SLP, 1, "R5 sleep entered");
    step(0, 2'b00, 0, 1, 0, 0, 1, V_SLP, 1, "R5 snoop ignored 1");
    step(0, 2'b00, 0, 1, 0, 0, 1, V_SLP, 1, "R5 snoop ignored 2");
    step(0, 2'b00, 0, 0, 1, 0, 1, V_RUN, 1, "R7 wake from sleep");
    step(1, 2'b11, 0, 0, 0, 0, 1, V_QS,  1, "R2 deep request");
    step(0, 2'b00, 1, 0, 0, 0, 1, V_DSL, 1, "R6 deep entered");
    step(0, 2'b00, 0, 1, 0, 0, 1, V_DSL, 1, "R6 snoop ignored");
    step(0, 2'b00, 0, 0, 1, 0, 1, V_RLK, 1, "R8 relock entered");
    for (int i = 0; i < 3; i++)
      step(0, 2'b00, 0, 0, 0, 0, 1, V_RLK, 1, "R8 waiting lock");
    step(0, 2'b00, 0, 0, 0, 1, 1, V_RLK, 1, "R8 lock seen");
    for (int i = 0; i < 3; i++)
      step(0, 2'b00, 0, 0, 0, 1, 1, V_RLK, 1, "R8 settling");
    step(0, 2'b00, 0, 0, 0, 0, 1, V_RLK, 1, "R8 lock lost");
    step(0, 2'b00, 0, 0, 0, 1, 1, V_RLK, 1, "R8 lock again");
    for (int i = 0; i < SETTLE - 1; i++)
      step(0, 2'b00, 0, 0, 0, 1, 1, V_RLK, 1, "R8 full settle");
    step(0, 2'b00, 0, 0, 0, 1, 1, V_RUN, 1, "R8 run after settle");
    step(1, 2'b01, 0, 0, 0, 1, 0, V_QS,  0, "R2 nap request again");
    step(0, 2'b00, 0, 0, 1, 1, 0, V_RUN, 0, "R7 wake aborts quiesce");
    step(0, 2'b00, 0, 0, 0, 1, 0, V_RUN, 0, "R9 dfs cleared");
    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule